// File: doc/BRIEF.md
# MDIO Management Slave Register Port

This block is the PHY-side endpoint of a two-wire serial management link. It samples the management clock and the bidirectional data line into the system clock domain and decodes each management frame. Matching frames then either read or write one of 32 sixteen-bit registers. The register storage sits outside the block and is reached through a plain register bus: an address, a one-cycle write strobe with write data, and a read-data return.

A frame is recognised only after at least 32 consecutive one bits. After that a start of 0 then 1 must follow, then a two-bit opcode, the PHY address and the register address. The block acts only when the frame's PHY address equals its local address. The local address comes out of reset as 1Fh, and a configuration load replaces it. On a read the block stays off the line for the first turnaround bit. It then drives a zero and the sixteen data bits through an output enable. A malformed start, opcode or write turnaround sends it back to hunting for a fresh preamble.

Top module: `mdio_slave_port`

## Requirements
- R1: After reset the output enable is low, no write strobe is issued, and the local PHY address is 1Fh.
- R2: A pulse on `cfg_load` replaces the local PHY address with `cfg_addr`. Frames to the new address are served, and frames to the old address are ignored.
- R3: A start is accepted only after 32 or more consecutive one bits sampled on MDC rising edges. A frame preceded by only 31 ones has no effect.
- R4: The bit pair after the start is the opcode, received first bit first: 1,0 selects read and 0,1 selects write. Any other opcode drops the frame, and a following frame without a new 32-one preamble is ignored.
- R5: On a matching read, the output enable stays low through the first turnaround bit. The block then drives 0 for the second turnaround bit and the 16 register bits, MSB first. The driven value changes only after MDC falling edges.
- R6: The output enable returns low on the MDC falling edge that follows the last read data bit.
- R7: On a write, the turnaround bits must be 1 then 0. Any other pair drops the frame with no write.
- R8: A matching write gives exactly one single-cycle write strobe after the 16th data bit. The strobe carries the 5-bit register address (MSB first on the line) and the 16-bit data (MSB first).
- R9: A frame whose PHY address (5 bits, MSB first) differs from the local address never drives MDIO and never writes.
- R10: A zero where the second start bit (a one) is expected drops the frame, and a new 32-one preamble is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_addr | input | 5 | New local PHY address |
| cfg_load | input | 1 | Loads `cfg_addr` into the local address |
| mdc | input | 1 | Management clock from the station |
| mdio_i | input | 1 | Resolved level of the MDIO line |
| mdio_o | output | 1 | Value driven on MDIO when enabled |
| mdio_oe | output | 1 | MDIO output enable |
| reg_addr | output | 5 | Register address of the current frame |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_wr_data | output | 16 | Register write data |
| reg_rd_data | input | 16 | Read data for `reg_addr` |

## Verification
The hardest case to reach is a frame that is well formed but has to be refused because of what came before it. Examples are a frame after only 31 ones, or a clean frame sent straight after a bad start or a bad opcode with no new preamble. The stimulus builds these out of single MDC bit cycles, so preamble length, start and opcode are set bit by bit. Every refusal is then confirmed by a read through the same link, which shows the targeted register still holds its earlier value. The local address is swept over all 32 values, and each value is checked against a matching and a neighbouring frame address.

// File: rtl/mdio_slave_pkg.sv
// Package: shared widths and the frame decoder state type.
// Assumes: Clause 22 style frames with 5-bit addresses and 16-bit data.
package mdio_slave_pkg;
    localparam int ADDR_W_DEF = 5;
    localparam int DATA_W_DEF = 16;
    localparam int PRE_LEN_DEF = 32;

    typedef enum logic [2:0] {
        ST_HUNT  = 3'd0,
        ST_START = 3'd1,
        ST_OP    = 3'd2,
        ST_PHY   = 3'd3,
        ST_REG   = 3'd4,
        ST_TA    = 3'd5,
        ST_DATA  = 3'd6
    } frame_state_t;
endpackage

// File: rtl/mdio_pin_sync.sv
// Module: brings MDC and MDIO into the system clock domain through a
// flop chain and flags MDC rising and falling edges for one cycle each.
// Assumes: MDC half period is longer than STAGES+1 system clocks.
module mdio_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mdc,
    input  logic mdio_i,
    output logic mdc_rise,
    output logic mdc_fall,
    output logic mdio_s
);
    logic [STAGES-1:0] mdc_chain;
    logic [STAGES-1:0] dat_chain;
    logic              mdc_last;

    // Synchroniser chains plus previous MDC level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdc_chain <= '0;
            dat_chain <= '1;
            mdc_last  <= 1'b0;
        end else begin
            mdc_chain <= {mdc_chain[STAGES-2:0], mdc};
            dat_chain <= {dat_chain[STAGES-2:0], mdio_i};
            mdc_last  <= mdc_chain[STAGES-1];
        end
    end

    // Edge flags and the data bit aligned with the MDC chain.
    always_comb begin
        mdc_rise = mdc_chain[STAGES-1] & ~mdc_last;
        mdc_fall = ~mdc_chain[STAGES-1] & mdc_last;
        mdio_s   = dat_chain[STAGES-1];
    end
endmodule

// File: rtl/mdio_frame_rx.sv
// Module: bit-level frame decoder. It counts preamble ones, checks the
// start, opcode and write turnaround, collects the addresses and write
// data, and raises the write strobe and the read drive controls.
// Assumes: bit_in is valid in the cycle where rise is high.
module mdio_frame_rx
    import mdio_slave_pkg::*;
#(
    parameter int ADDR_W  = ADDR_W_DEF,
    parameter int DATA_W  = DATA_W_DEF,
    parameter int PRE_LEN = PRE_LEN_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise,
    input  logic              bit_in,
    input  logic [ADDR_W-1:0] local_addr,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              rd_load,
    output logic              drv_zero,
    output logic              drv_data
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam int ONE_W = $clog2(PRE_LEN + 1);

    frame_state_t      state;
    logic [CNT_W-1:0]  cnt;
    logic [ONE_W-1:0]  ones;
    logic              op_first;
    logic              is_rd;
    logic              match;
    logic [ADDR_W-1:0] phy_sr;

    // Frame sequencing, advanced once per sampled MDC rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_HUNT;
            cnt      <= '0;
            ones     <= '0;
            op_first <= 1'b0;
            is_rd    <= 1'b0;
            match    <= 1'b0;
            phy_sr   <= '0;
            reg_addr <= '0;
            wr_data  <= '0;
            wr_en    <= 1'b0;
            rd_load  <= 1'b0;
        end else begin
            wr_en   <= 1'b0;
            rd_load <= 1'b0;
            if (rise) begin
                case (state)
                    ST_HUNT: begin
                        if (bit_in) begin
                            if (ones != ONE_W'(PRE_LEN)) ones <= ones + 1'b1;
                        end else begin
                            if (ones == ONE_W'(PRE_LEN)) state <= ST_START;
                            ones <= '0;
                        end
                    end
                    ST_START: begin
                        cnt   <= '0;
                        state <= bit_in ? ST_OP : ST_HUNT;
                    end
                    ST_OP: begin
                        if (cnt == '0) begin
                            op_first <= bit_in;
                            cnt      <= cnt + 1'b1;
                        end else begin
                            cnt <= '0;
                            if (op_first != bit_in) begin
                                is_rd <= op_first;
                                state <= ST_PHY;
                            end else begin
                                state <= ST_HUNT;
                            end
                        end
                    end
                    ST_PHY: begin
                        phy_sr <= {phy_sr[ADDR_W-2:0], bit_in};
                        if (cnt == CNT_W'(ADDR_W - 1)) begin
                            cnt   <= '0;
                            match <= ({phy_sr[ADDR_W-2:0], bit_in} == local_addr);
                            state <= ST_REG;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_REG: begin
                        reg_addr <= {reg_addr[ADDR_W-2:0], bit_in};
                        if (cnt == CNT_W'(ADDR_W - 1)) begin
                            cnt   <= '0;
                            state <= ST_TA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_TA: begin
                        if (cnt == '0) begin
                            cnt <= cnt + 1'b1;
                            if (is_rd) rd_load <= match;
                            else if (!bit_in) state <= ST_HUNT;
                        end else begin
                            cnt   <= '0;
                            state <= (!is_rd && bit_in) ? ST_HUNT : ST_DATA;
                        end
                    end
                    ST_DATA: begin
                        if (!is_rd) wr_data <= {wr_data[DATA_W-2:0], bit_in};
                        if (cnt == CNT_W'(DATA_W - 1)) begin
                            cnt   <= '0;
                            state <= ST_HUNT;
                            wr_en <= match & ~is_rd;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: state <= ST_HUNT;
                endcase
            end
        end
    end

    // Drive requests for the output stage during a matching read.
    always_comb begin
        drv_zero = (state == ST_TA) && (cnt == CNT_W'(1)) && is_rd && match;
        drv_data = (state == ST_DATA) && is_rd && match;
    end
endmodule

// File: rtl/mdio_tx_drive.sv
// Module: read-side output stage. It latches the register word and, on
// each MDC falling edge, sets the enable and the driven bit.
// Assumes: drv_zero and drv_data are never high together.
module mdio_tx_drive #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall,
    input  logic              load,
    input  logic [DATA_W-1:0] rdata,
    input  logic              drv_zero,
    input  logic              drv_data,
    output logic              mdio_o,
    output logic              mdio_oe
);
    logic [DATA_W-1:0] sh;

    // Word capture and falling-edge update of the enable and output bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh      <= '0;
            mdio_o  <= 1'b0;
            mdio_oe <= 1'b0;
        end else begin
            if (load) sh <= rdata;
            if (fall) begin
                mdio_oe <= drv_zero | drv_data;
                mdio_o  <= drv_data & sh[DATA_W-1];
                if (drv_data) sh <= {sh[DATA_W-2:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/mdio_slave_port.sv
// Module: top of the management slave. It holds the local PHY address
// and joins the pin synchroniser, the frame decoder and the output stage.
// Assumes: the external register file answers reg_rd_data for reg_addr
// within the same cycle.
module mdio_slave_port
    import mdio_slave_pkg::*;
#(
    parameter int ADDR_W     = ADDR_W_DEF,
    parameter int DATA_W     = DATA_W_DEF,
    parameter int PRE_LEN    = PRE_LEN_DEF,
    parameter int SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              cfg_load,
    input  logic              mdc,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_wr_en,
    output logic [DATA_W-1:0] reg_wr_data,
    input  logic [DATA_W-1:0] reg_rd_data
);
    logic              mdc_rise;
    logic              mdc_fall;
    logic              mdio_s;
    logic              rd_load;
    logic              drv_zero;
    logic              drv_data;
    logic [ADDR_W-1:0] local_addr;

    // Local PHY address register with configuration load.
    always_ff @(posedge clk) begin
        if (!rst_n)        local_addr <= RESET_ADDR;
        else if (cfg_load) local_addr <= cfg_addr;
    end

    mdio_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .mdc      (mdc),
        .mdio_i   (mdio_i),
        .mdc_rise (mdc_rise),
        .mdc_fall (mdc_fall),
        .mdio_s   (mdio_s)
    );

    mdio_frame_rx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRE_LEN(PRE_LEN)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise       (mdc_rise),
        .bit_in     (mdio_s),
        .local_addr (local_addr),
        .reg_addr   (reg_addr),
        .wr_en      (reg_wr_en),
        .wr_data    (reg_wr_data),
        .rd_load    (rd_load),
        .drv_zero   (drv_zero),
        .drv_data   (drv_data)
    );

    mdio_tx_drive #(.DATA_W(DATA_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .fall     (mdc_fall),
        .load     (rd_load),
        .rdata    (reg_rd_data),
        .drv_zero (drv_zero),
        .drv_data (drv_data),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe)
    );
endmodule

// File: rtl/mdio_slave_chk.sv
// Module: protocol checker for the management slave, bound to the top.
// Assumes: edge flags come from the synchroniser inside the top.
module mdio_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic mdc_rise,
    input logic mdc_fall,
    input logic mdio_o,
    input logic mdio_oe,
    input logic reg_wr_en
);
    AST_WR_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en); // R8
    AST_WR_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> $past(mdc_rise)); // R8
    AST_WR_NOT_DRIVING: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> !mdio_oe); // R9
    AST_OE_FIRST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdio_oe) |-> !mdio_o); // R5
    AST_OE_RISE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdio_oe) |-> $past(mdc_fall)); // R5
    AST_OUT_CHANGE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_oe && $past(mdio_oe) && !$stable(mdio_o)) |-> $past(mdc_fall)); // R5
    AST_OE_DROP_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mdio_oe) |-> $past(mdc_fall)); // R6
endmodule

bind mdio_slave_port mdio_slave_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mdc_rise  (mdc_rise),
    .mdc_fall  (mdc_fall),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .reg_wr_en (reg_wr_en)
);

// File: tb/tb_mdio_slave_port.sv
// Bench: drives MDC/MDIO bit by bit as a station would, models the
// register file, and compares against values computed from the address.
module tb_mdio_slave_port;
    localparam int HP = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  cfg_addr = 5'h0;
    logic        cfg_load = 1'b0;
    logic        mdc = 1'b0;
    logic        m_en = 1'b0;
    logic        m_val = 1'b1;
    logic        mdio_o;
    logic        mdio_oe;
    logic [4:0]  reg_addr;
    logic        reg_wr_en;
    logic [15:0] reg_wr_data;
    logic [15:0] reg_rd_data;
    logic        line;
    logic [15:0] rf [32];
    int          wr_cnt = 0;
    int          n_chk = 0;
    int          n_bad = 0;

    always #10 clk = ~clk;

    assign line = mdio_oe ? mdio_o : (m_en ? m_val : 1'b1);
    assign reg_rd_data = rf[reg_addr];

    mdio_slave_port dut (
        .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_load(cfg_load),
        .mdc(mdc), .mdio_i(line), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .reg_rd_data(reg_rd_data)
    );

    always @(posedge clk) begin
        if (reg_wr_en) begin
            rf[reg_addr] <= reg_wr_data;
            wr_cnt <= wr_cnt + 1;
        end
    end

    function automatic logic [15:0] pat(input int a, input int k);
        return 16'((a * 16'h0B3D + k * 16'h2F11) ^ 16'h5A96);
    endfunction

    task automatic chk(input longint act, input longint exp, input string req);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One MDC cycle; samples enable and line just before the rising edge.
    task automatic bit_cyc(input logic en, input logic b,
                           output logic s_oe, output logic s_line);
        m_en = en; m_val = b;
        repeat (HP) @(negedge clk);
        s_oe = mdio_oe; s_line = line;
        mdc = 1'b1;
        repeat (HP) @(negedge clk);
        mdc = 1'b0;
    endtask

    task automatic send(input logic b);
        logic o, l;
        bit_cyc(1'b1, b, o, l);
    endtask

    task automatic pre(input int n);
        for (int i = 0; i < n; i++) send(1'b1);
    endtask

    task automatic hdr(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] ra);
        send(1'b0); send(1'b1);
        send(op[1]); send(op[0]);
        for (int i = 4; i >= 0; i--) send(phy[i]);
        for (int i = 4; i >= 0; i--) send(ra[i]);
    endtask

    task automatic wr_body(input logic [1:0] ta, input logic [15:0] d);
        send(ta[1]); send(ta[0]);
        for (int i = 15; i >= 0; i--) send(d[i]);
        m_en = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic write_frame(input int npre, input logic [4:0] phy,
                               input logic [4:0] ra, input logic [15:0] d);
        pre(npre);
        hdr(2'b01, phy, ra);
        wr_body(2'b10, d);
    endtask

    // Read frame: returns data, TA observations and trailing enable.
    task automatic read_frame(input logic [4:0] phy, input logic [4:0] ra,
                              output logic [15:0] d, output logic ta1_oe,
                              output logic [1:0] ta2, output logic all_oe,
                              output logic any_oe, output logic end_oe);
        logic o, l;
        pre(32);
        hdr(2'b10, phy, ra);
        bit_cyc(1'b0, 1'b1, ta1_oe, l);
        any_oe = ta1_oe;
        bit_cyc(1'b0, 1'b1, o, l);
        ta2 = {o, l};
        any_oe |= o;
        all_oe = 1'b1;
        for (int i = 15; i >= 0; i--) begin
            bit_cyc(1'b0, 1'b1, o, l);
            d[i] = l; all_oe &= o; any_oe |= o;
        end
        repeat (HP) @(negedge clk);
        end_oe = mdio_oe;
    endtask

    task automatic read_check(input logic [4:0] phy, input logic [4:0] ra,
                              input logic [15:0] exp, input string req);
        logic [15:0] d; logic t1, ao, an, eo; logic [1:0] t2;
        read_frame(phy, ra, d, t1, t2, ao, an, eo);
        chk(d, exp, req);
    endtask

    task automatic read_silent(input logic [4:0] phy, input logic [4:0] ra, input string req);
        logic [15:0] d; logic t1, ao, an, eo; logic [1:0] t2;
        read_frame(phy, ra, d, t1, t2, ao, an, eo);
        chk(an, 1'b0, req);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : stim
        logic [15:0] d; logic t1, ao, an, eo; logic [1:0] t2;
        int w0;
        for (int i = 0; i < 32; i++) rf[i] = 16'h0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1: reset state
        chk(mdio_oe, 0, "R1 oe");
        chk(reg_wr_en, 0, "R1 wr");

        // R8 / R4: write every register at the reset address 1Fh (R1)
        for (int a = 0; a < 32; a++) begin
            w0 = wr_cnt;
            write_frame(32, 5'h1F, 5'(a), pat(a, 0));
            chk(wr_cnt - w0, 1, "R8 strobe count");
            chk(rf[a], pat(a, 0), "R8 R1 write data");
        end

        // R5 / R6: read every register back
        for (int a = 0; a < 32; a++) begin
            read_frame(5'h1F, 5'(a), d, t1, t2, ao, an, eo);
            chk(d, pat(a, 0), "R5 read data");
            chk({t1, t2, ao, eo}, {1'b0, 2'b10, 1'b1, 1'b0}, "R5 R6 turnaround and enable");
        end

        // R9: mismatched PHY address
        w0 = wr_cnt;
        write_frame(32, 5'h03, 5'd5, 16'hDEAD);
        chk(wr_cnt - w0, 0, "R9 no write");
        read_silent(5'h03, 5'd5, "R9 never drives");
        read_check(5'h1F, 5'd5, pat(5, 0), "R9 register unchanged");

        // R3: 31 ones of preamble is not enough
        w0 = wr_cnt;
        write_frame(31, 5'h1F, 5'd6, 16'h1234);
        chk(wr_cnt - w0, 0, "R3 short preamble");
        read_check(5'h1F, 5'd6, pat(6, 0), "R3 register unchanged");
        w0 = wr_cnt;
        write_frame(40, 5'h1F, 5'd6, 16'h1234);
        chk(wr_cnt - w0, 1, "R3 long preamble accepted");
        read_check(5'h1F, 5'd6, 16'h1234, "R3 long preamble data");

        // R4: bad opcode 00, then a frame without fresh preamble
        w0 = wr_cnt;
        pre(32); hdr(2'b00, 5'h1F, 5'd7); wr_body(2'b10, 16'hAAAA);
        hdr(2'b01, 5'h1F, 5'd7); wr_body(2'b10, 16'hBBBB);
        chk(wr_cnt - w0, 0, "R4 bad opcode and no resync");
        read_check(5'h1F, 5'd7, pat(7, 0), "R4 register unchanged");
        w0 = wr_cnt;
        pre(32); hdr(2'b11, 5'h1F, 5'd7); wr_body(2'b10, 16'hCCCC);
        chk(wr_cnt - w0, 0, "R4 opcode 11");

        // R10: bad start (0,0) then a frame without preamble
        w0 = wr_cnt;
        pre(32); send(1'b0);
        hdr(2'b01, 5'h1F, 5'd8); wr_body(2'b10, 16'h7777);
        chk(wr_cnt - w0, 0, "R10 bad start");
        read_check(5'h1F, 5'd8, pat(8, 0), "R10 register unchanged");

        // R7: invalid write turnaround pairs
        w0 = wr_cnt;
        pre(32); hdr(2'b01, 5'h1F, 5'd9); wr_body(2'b11, 16'h4444);
        pre(32); hdr(2'b01, 5'h1F, 5'd9); wr_body(2'b00, 16'h5555);
        pre(32); hdr(2'b01, 5'h1F, 5'd9); wr_body(2'b01, 16'h6666);
        chk(wr_cnt - w0, 0, "R7 bad turnaround");
        read_check(5'h1F, 5'd9, pat(9, 0), "R7 register unchanged");

        // R2: sweep every local address against itself and a neighbour
        for (int a = 0; a < 32; a++) begin
            @(negedge clk); cfg_addr = 5'(a); cfg_load = 1'b1;
            @(negedge clk); cfg_load = 1'b0;
            w0 = wr_cnt;
            write_frame(32, 5'(a ^ 1), 5'(a), 16'hFFFF);
            chk(wr_cnt - w0, 0, "R2 R9 neighbour address ignored");
            write_frame(32, 5'(a), 5'(a), pat(a, 1));
            chk(wr_cnt - w0, 1, "R2 new address served");
            chk(rf[a], pat(a, 1), "R2 write data");
        end
        read_check(5'd31, 5'd3, pat(3, 1), "R2 read at loaded address");
        read_silent(5'd30, 5'd3, "R2 old neighbour silent");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule